// File: doc/BRIEF.md
# Comparator Timer Channel

This block is one comparator channel placed next to a free-running 32-bit up-counter that lives outside it. Software programs a compare value through a small word-addressed register port. When the counter reaches that value, the channel fires and raises an interrupt. The compare is a plain equality on 32 bits, so a target that lies past the counter's wrap point still fires once the counter wraps. In one-shot mode the channel fires once per programming. In periodic mode it reloads itself by adding a stored period to the compare value on every match.

Periodic programming takes two compare writes. The first write is made with the set-value bit high: it loads the compare value and the bit then clears by itself. The second write, made with the bit low, stores the period. A fire is delivered on one of two paths. The first is the interrupt line, as a one-cycle pulse in edge mode or as a held level that software acknowledges through a status word. The second is a message strobe that carries a programmed data word and address word. When the message path is enabled, the interrupt line stays low.

Register words, by index on `reg_addr`: 0 configuration, 1 compare, 2 message data, 3 message address low, 4 message address high (always zero), 5 status. Configuration bits: 0 enable, 1 periodic, 2 level, 3 set-value, 4 32-bit mode (stored only; the datapath is 32 bits wide), 5 message enable, 8 periodic capability (read-only), 9 message capability (read-only). Status bit 0 is the pending level interrupt. Writing 1 to it clears it.

Top module: `cmp_timer_chan`

## Requirements
- R1: After reset, the configuration word reads 0x300 (only the two capability bits set), the compare word reads 0xFFFFFFFF, the message words and the status word read 0, and no output is active.
- R2: In one-shot mode with enable set, the channel fires exactly once when the counter input equals the compare value, including a target reached only after the counter wraps. It does not fire again at that value until the compare or configuration word is written.
- R3: A compare write while set-value (bit 3) is 1 loads the compare value, and bit 3 then reads 0.
- R4: In periodic mode, a compare write with set-value at 0 stores the period. The channel fires at the loaded compare value C and then at C+P, C+2P, and so on (modulo 2^32).
- R5: Reading word 1 returns the value last written to it, whether that write loaded the compare or the period.
- R6: Word 2 holds the message data and word 3 holds the message address, and both read back as written. Word 4 always reads 0 and ignores writes.
- R7: While enable (bit 0) is 0, no fire reaches either output. Clearing it before a pending match suppresses that match.
- R8: With message enable (bit 5) set, each fire produces a one-cycle `msg_valid_o` carrying the data and address words, and `irq_o` stays low. Clearing bit 5 returns delivery to `irq_o` and leaves the compare logic untouched.
- R9: In edge mode (bit 2 = 0), a match at clock edge k gives an `irq_o` pulse exactly one cycle wide, starting after edge k.
- R10: In level mode (bit 2 = 1), `irq_o` rises after the match and stays high until a write of 1 to status bit 0. Status bit 0 reads 1 while the interrupt is pending.
- R11: The capability bits 8 and 9 are read-only. Writing 0 to them leaves them reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 32 | Free-running counter value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_o | output | 1 | Interrupt line, pulse or level |
| msg_valid_o | output | 1 | Message strobe, one cycle per fire |
| msg_data_o | output | 32 | Message data word |
| msg_addr_o | output | 32 | Message address word |

## Verification
The hardest case to reach from the ports is a compare target that only matches after the 32-bit counter wraps. Waiting for a real wrap is out of the question, so the bench builds the counter as a tick plus an offset that it can move. It places the count a few steps below the all-ones value and then writes a target just past zero. The same offset jump sends the counter back below a target that has already fired, which shows that one-shot mode stays quiet until it is rearmed. The periodic sweep uses several period values and checks each successive fire position against C+kP, computed in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CFG    = 3'd0;
  localparam logic [AW-1:0] A_CMP    = 3'd1;
  localparam logic [AW-1:0] A_MDATA  = 3'd2;
  localparam logic [AW-1:0] A_MADDR  = 3'd3;
  localparam logic [AW-1:0] A_MADDRH = 3'd4;
  localparam logic [AW-1:0] A_STAT   = 3'd5;

  localparam int B_EN = 0, B_PER = 1, B_LVL = 2, B_SET = 3, B_M32 = 4, B_MSG = 5;
  localparam int B_CAPP = 8, B_CAPM = 9;

  typedef struct packed {
    logic en;
    logic per;
    logic lvl;
    logic setv;
    logic m32;
    logic msg;
  } cfg_t;

  function automatic logic [DW-1:0] step_cmp(input logic [DW-1:0] cur, input logic [DW-1:0] per);
    return cur + per;
  endfunction

  function automatic logic [DW-1:0] pack_cfg(input cfg_t c, input logic capp, input logic capm);
    logic [DW-1:0] w;
    w = '0;
    w[B_EN] = c.en;   w[B_PER] = c.per;  w[B_LVL] = c.lvl;
    w[B_SET] = c.setv; w[B_M32] = c.m32; w[B_MSG] = c.msg;
    w[B_CAPP] = capp; w[B_CAPM] = capm;
    return w;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter bit CAP_PER = 1'b1,
  parameter bit CAP_MSG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          fire,
  output cfg_t          cfg,
  output logic [DW-1:0] cmp,
  output logic [DW-1:0] echo,
  output logic [DW-1:0] mdata,
  output logic [DW-1:0] maddr,
  output logic          cfg_wr,
  output logic          cmp_wr
);
  logic [DW-1:0] period;

  assign cfg_wr = reg_wr && (reg_addr == A_CFG);
  assign cmp_wr = reg_wr && (reg_addr == A_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      cmp    <= '1;
      period <= '1;
      echo   <= '1;
      mdata  <= '0;
      maddr  <= '0;
    end else begin
      if (cfg_wr) begin
        cfg.en   <= reg_wdata[B_EN];
        cfg.per  <= reg_wdata[B_PER] & CAP_PER;
        cfg.lvl  <= reg_wdata[B_LVL];
        cfg.setv <= reg_wdata[B_SET];
        cfg.m32  <= reg_wdata[B_M32];
        cfg.msg  <= reg_wdata[B_MSG] & CAP_MSG;
      end
      if (reg_wr && reg_addr == A_MDATA) mdata <= reg_wdata;
      if (reg_wr && reg_addr == A_MADDR) maddr <= reg_wdata;
      if (cmp_wr) begin
        echo <= reg_wdata;
        if (cfg.setv) begin
          cmp      <= reg_wdata;
          cfg.setv <= 1'b0;
        end else if (cfg.per) begin
          period <= reg_wdata;
        end else begin
          cmp <= reg_wdata;
        end
      end else if (fire && cfg.per) begin
        cmp <= step_cmp(cmp, period);
      end
    end
  end

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cfg.setv) |=> (!cfg.setv && cmp == $past(reg_wdata))); // R3

  AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg.per && !cmp_wr) |=> (cmp == $past(cmp) + $past(period))); // R4
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] cmp,
  input  logic          en,
  input  logic          per,
  input  logic          rearm,
  output logic          fire
);
  logic armed;

  assign fire = en && armed && (count_i == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)             armed <= 1'b1;
    else if (rearm)         armed <= 1'b1;
    else if (fire && !per)  armed <= 1'b0;
  end

  AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per && !rearm) |=> !fire); // R2
endmodule

// File: rtl/tmr_deliver.sv
module tmr_deliver (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic en,
  input  logic lvl,
  input  logic msg,
  input  logic ack,
  output logic pending,
  output logic irq_o,
  output logic msg_valid_o
);
  logic edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q      <= 1'b0;
      msg_valid_o <= 1'b0;
      pending     <= 1'b0;
    end else begin
      edge_q      <= fire && !msg && !lvl;
      msg_valid_o <= fire && msg;
      if (fire && lvl && !msg) pending <= 1'b1;
      else if (ack)            pending <= 1'b0;
    end
  end

  assign irq_o = en && (lvl ? (pending && !msg) : edge_q);

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R10

  AST_MSG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> !irq_o); // R8
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import tmr_pkg::*;
#(
  parameter bit CAP_PER = 1'b1,
  parameter bit CAP_MSG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   count_i,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_o,
  output logic          msg_valid_o,
  output logic [31:0]   msg_data_o,
  output logic [31:0]   msg_addr_o
);
  cfg_t          cfg;
  logic [DW-1:0] cmp, echo, mdata, maddr;
  logic          cfg_wr, cmp_wr, fire, pending, ack;

  assign ack = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

  tmr_regs #(.CAP_PER(CAP_PER), .CAP_MSG(CAP_MSG)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fire(fire), .cfg(cfg), .cmp(cmp), .echo(echo),
    .mdata(mdata), .maddr(maddr), .cfg_wr(cfg_wr), .cmp_wr(cmp_wr));

  tmr_match u_match (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .cmp(cmp), .en(cfg.en),
    .per(cfg.per), .rearm(cfg_wr || cmp_wr), .fire(fire));

  tmr_deliver u_dlv (
    .clk(clk), .rst_n(rst_n), .fire(fire), .en(cfg.en), .lvl(cfg.lvl),
    .msg(cfg.msg), .ack(ack), .pending(pending), .irq_o(irq_o),
    .msg_valid_o(msg_valid_o));

  assign msg_data_o = mdata;
  assign msg_addr_o = maddr;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = pack_cfg(cfg, CAP_PER, CAP_MSG);
      A_CMP:   reg_rdata = echo;
      A_MDATA: reg_rdata = mdata;
      A_MADDR: reg_rdata = maddr;
      A_STAT:  reg_rdata = {{(DW-1){1'b0}}, pending};
      default: reg_rdata = '0;
    endcase
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !msg_valid_o); // R7

  AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CFG) |-> (reg_rdata[B_CAPP] == CAP_PER && reg_rdata[B_CAPM] == CAP_MSG)); // R11
endmodule

// File: tb/sim_cmp_timer_chan.sv
module sim_cmp_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tick = 32'd0;
  logic [31:0] off = 32'd0;
  wire  [31:0] count = tick + off;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  wire  [31:0] reg_rdata;
  wire         irq_o, msg_valid_o;
  wire  [31:0] msg_data_o, msg_addr_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  localparam logic [31:0] EN = 32'h1, PER = 32'h2, LVL = 32'h4, SETV = 32'h8, MSG = 32'h20;

  cmp_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .count_i(count), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .msg_valid_o(msg_valid_o), .msg_data_o(msg_data_o), .msg_addr_o(msg_addr_o));

  always #10 clk = ~clk;
  always @(posedge clk) tick <= tick + 32'd1;

  // event monitor: a fire at edge k shows after edge k, when count is one past the match
  logic [31:0] ev_at [0:63];
  int n_ev = 0, n_hi = 0, n_msg = 0;
  logic irq_prev = 1'b0;
  logic [31:0] m_data = 0, m_addr = 0, m_at = 0;
  always @(posedge clk) begin
    #5;
    if (irq_o) begin
      n_hi++;
      if (!irq_prev) begin
        if (n_ev < 64) ev_at[n_ev] = count - 32'd1;
        n_ev++;
      end
    end
    irq_prev = irq_o;
    if (msg_valid_o) begin
      n_msg++;
      m_data = msg_data_o; m_addr = msg_addr_o; m_at = count - 32'd1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    int b, h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk(v == 32'h300, "R1 cfg", v, 32'h300);
    rd(3'd1, v); chk(v == 32'hFFFFFFFF, "R1 cmp", v, 32'hFFFFFFFF);
    rd(3'd2, v); chk(v == 0, "R1 mdata", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 maddr", v, 0);
    rd(3'd5, v); chk(v == 0, "R1 status", v, 0);
    chk(!irq_o && !msg_valid_o, "R1 outputs", {30'd0, irq_o, msg_valid_o}, 0);
    // R11 capability bits read-only
    wr(3'd0, 32'h0); rd(3'd0, v); chk(v == 32'h300, "R11 caps", v, 32'h300);

    // R2 R9 R5 one-shot edge sweep, last target wraps
    wr(3'd0, EN);
    for (int i = 0; i < 4; i++) begin
      if (i == 3) off = 32'hFFFFFFF5 - tick;
      @(negedge clk);
      c = count + 32'd3 + 32'(i * 6);
      b = n_ev; h = n_hi;
      wr(3'd1, c);
      rd(3'd1, v); chk(v == c, "R5 cmp readback", v, c);
      wait_cyc(4 + i * 6 + 6);
      chk(n_ev == b + 1, "R2 one fire", n_ev - b, 1);
      chk(ev_at[b] == c, "R2 match point", ev_at[b], c);
      chk(n_hi == h + 1, "R9 pulse width", n_hi - h, 1);
      // revisit the value: no second fire until rearmed
      off = off - 32'd20;
      wait_cyc(30);
      chk(n_ev == b + 1, "R2 no refire", n_ev - b, 1);
    end

    // R3 R4 R5 periodic sweep
    for (int p = 0; p < 3; p++) begin
      logic [31:0] per;
      per = (p == 0) ? 32'd4 : (p == 1) ? 32'd5 : 32'd9;
      wr(3'd0, EN | PER | SETV);
      rd(3'd0, v); chk(v[3] == 1'b1, "R3 setval set", v, 32'h30B);
      c = count + 32'd12;
      wr(3'd1, c);
      rd(3'd0, v); chk(v[3] == 1'b0, "R3 setval cleared", v, 32'h303);
      b = n_ev;
      wr(3'd1, per);
      rd(3'd1, v); chk(v == per, "R5 period readback", v, per);
      wait_cyc(12 + 4 * int'(per) + 4);
      for (int k = 0; k < 4; k++)
        chk(ev_at[b + k] == c + per * k, "R4 periodic step", ev_at[b + k], c + per * k);
      wr(3'd0, 32'h0);
      b = n_ev;
      wait_cyc(3 * int'(per) + 2);
      chk(n_ev == b, "R7 periodic stopped", n_ev - b, 0);
    end

    // R7 disable before match
    wr(3'd0, EN);
    c = count + 32'd8;
    b = n_ev;
    wr(3'd1, c);
    wr(3'd0, 32'h0);
    wait_cyc(14);
    chk(n_ev == b && !irq_o, "R7 suppressed", n_ev - b, 0);

    // R10 level mode
    wr(3'd0, EN | LVL);
    c = count + 32'd5;
    b = n_ev;
    wr(3'd1, c);
    wait_cyc(10);
    chk(irq_o == 1'b1, "R10 level high", {31'd0, irq_o}, 1);
    chk(ev_at[b] == c, "R10 match point", ev_at[b], c);
    rd(3'd5, v); chk(v == 1, "R10 status pending", v, 1);
    wait_cyc(6);
    chk(irq_o == 1'b1, "R10 level held", {31'd0, irq_o}, 1);
    wr(3'd5, 32'h1);
    chk(irq_o == 1'b0, "R10 cleared", {31'd0, irq_o}, 0);
    rd(3'd5, v); chk(v == 0, "R10 status cleared", v, 0);

    // R6 route words
    wr(3'd2, 32'hA5A50001);
    wr(3'd3, 32'hFEE01000);
    wr(3'd4, 32'h12345678);
    rd(3'd2, v); chk(v == 32'hA5A50001, "R6 data", v, 32'hA5A50001);
    rd(3'd3, v); chk(v == 32'hFEE01000, "R6 addr", v, 32'hFEE01000);
    rd(3'd4, v); chk(v == 0, "R6 addr high zero", v, 0);

    // R8 message delivery
    wr(3'd0, EN | MSG);
    c = count + 32'd6;
    b = n_msg; h = n_hi;
    wr(3'd1, c);
    wait_cyc(12);
    chk(n_msg == b + 1, "R8 one message", n_msg - b, 1);
    chk(m_data == 32'hA5A50001, "R8 msg data", m_data, 32'hA5A50001);
    chk(m_addr == 32'hFEE01000, "R8 msg addr", m_addr, 32'hFEE01000);
    chk(m_at == c, "R8 msg point", m_at, c);
    chk(n_hi == h, "R8 irq quiet", n_hi - h, 0);
    // clearing message enable returns delivery to irq
    wr(3'd0, EN);
    c = count + 32'd6;
    b = n_ev;
    h = n_msg;
    wr(3'd1, c);
    wait_cyc(12);
    chk(n_ev == b + 1 && ev_at[b] == c, "R8 back to irq", ev_at[b], c);
    chk(n_msg == h, "R8 msg masked", n_msg - h, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule